// File: doc/BRIEF.md
# Fine Phase Shift Step Engine

This block models, cycle by cycle, the responding side of a fine phase adjustment port on a clock generator. It runs on a single phase-adjust clock. A requester raises a one-cycle request strobe together with a direction bit. The block then moves the phase of every chosen output by one step, where one step is a thirty-second of the oscillator period. It confirms the move with a one-cycle completion pulse a fixed number of cycles later.

Each output lane and the feedback lane hold their phase as an integer count. The count runs modulo 32 times the output divide value, so one full output period maps onto the whole count range and the phase wraps in both directions. A lane mask picks which lanes take part in a request. While no request is in flight, the completion pulse keeps repeating at a fixed idle spacing. This lets a requester that only watches the completion line stay in step.

Top module: `phase_step_engine`

## Requirements
- R1: After a synchronous reset, every lane phase reads 0, and `busy`, `ps_done` and `proto_err` are all 0.
- R2: A request accepted with `ps_dir`=1 adds one step to each selected lane. With `ps_dir`=0 it removes one step. Lanes change only at the completion edge.
- R3: `ps_done` is high for exactly one cycle, 12 clock edges after the edge that accepted the request. The lane phases take their new values on that same edge.
- R4: `busy` is high from the accepting edge until the completion edge, and low otherwise.
- R5: The lane phase runs modulo M = 32*OUT_DIV (128 by default). A step up from M-1 gives 0, and a step down from 0 gives M-1.
- R6: Bit i of `sel_mask` selects output lane i, and the top bit (index NUM_OUT) selects the feedback lane. The mask is captured when the request is accepted and changes to it later are ignored. Unselected lanes keep their phase.
- R7: With no request active, `ps_done` pulses once every 32 cycles. The first pulse comes 32 edges after the last reset edge.
- R8: The idle pulse spacing restarts at each completion, so the next idle pulse comes 32 edges after the last `ps_done`.
- R9: A request strobe seen while `busy` is high is dropped and changes no lane. It sets `proto_err`, which stays high until reset.
- R10: No idle pulse occurs while a request is in flight. An accepted request takes priority over an idle pulse due on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-adjust clock |
| rst | input | 1 | Synchronous reset, active high |
| ps_en | input | 1 | One-cycle request strobe |
| ps_dir | input | 1 | 1 = step up, 0 = step down |
| sel_mask | input | NUM_OUT+1 | Lane select; top bit is the feedback lane |
| ps_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in flight |
| proto_err | output | 1 | Sticky flag: request strobe seen while busy |
| chan_phase | output | (NUM_OUT+1)*PW | Packed lane phases, lane 0 in the low bits, PW = clog2(32*OUT_DIV) |

## Verification
A request strobe driven before edge n is accepted at edge n. From then on `busy` reads high, and `ps_done` and the new lane phases appear after edge n+12. When no request is in flight, an idle pulse is due 32 edges after the previous pulse, whichever kind it was. The scoreboard stores the accepting edge, the due edge and the expected phases for each request. At every falling edge the monitor compares `ps_done`, `busy` and all lane phases against what is due for the edge just passed. This fixes every result to its exact cycle, not merely to its eventual arrival.

// File: rtl/ps_step_pkg.sv
package ps_step_pkg;

  // One phase step with wraparound in both directions
  function automatic int unsigned wrap_step(int unsigned cur, logic up,
                                            int unsigned modulus);
    if (up) return (cur >= modulus - 1) ? 0 : cur + 1;
    else    return (cur == 0) ? modulus - 1 : cur - 1;
  endfunction

  // Latency counter reload value
  function automatic int unsigned lat_reload(int unsigned latency);
    return (latency > 0) ? latency - 1 : 0;
  endfunction

endpackage

// File: rtl/ps_req_ctrl.sv
module ps_req_ctrl #(
  parameter int unsigned NCH     = 5,
  parameter int unsigned LATENCY = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ps_en,
  input  logic           ps_dir,
  input  logic [NCH-1:0] sel_in,
  output logic           accept_o,
  output logic           op_done_o,
  output logic           busy_o,
  output logic           dir_o,
  output logic [NCH-1:0] mask_o,
  output logic           err_o
);
  import ps_step_pkg::*;

  localparam int unsigned LW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [LW-1:0] RELOAD = LW'(lat_reload(LATENCY));

  logic [LW-1:0] lat_q;
  logic          busy_q, dir_q, err_q;
  logic [NCH-1:0] mask_q;
  logic          viol;

  assign accept_o  = ps_en && !busy_q;
  assign viol      = ps_en && busy_q;
  assign op_done_o = busy_q && (lat_q == '0);
  assign busy_o    = busy_q;
  assign dir_o     = dir_q;
  assign mask_o    = mask_q;
  assign err_o     = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
      dir_q  <= 1'b0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (accept_o) begin
        busy_q <= 1'b1;
        lat_q  <= RELOAD;
        dir_q  <= ps_dir;
        mask_q <= sel_in;
      end else if (busy_q) begin
        if (lat_q == '0) busy_q <= 1'b0;
        else             lat_q  <= lat_q - 1'b1;
      end
      if (viol) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ps_idle_timer.sv
module ps_idle_timer #(
  parameter int unsigned IDLE_PERIOD = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic accept,
  input  logic op_done,
  output logic idle_fire_o
);
  localparam int unsigned CW = (IDLE_PERIOD > 1) ? $clog2(IDLE_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign idle_fire_o = !busy && !accept && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (op_done || idle_fire_o)  cnt_q <= '0;
    else if (!busy && !accept)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ps_phase_lane.sv
module ps_phase_lane #(
  parameter int unsigned MOD = 128,
  parameter int unsigned PW  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          up,
  output logic [PW-1:0] phase_o
);
  import ps_step_pkg::*;

  logic [PW-1:0] phase_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= '0;
    else if (step_en) phase_q <= PW'(wrap_step(32'(phase_q), up, MOD));
  end
endmodule

// File: rtl/phase_step_engine.sv
module phase_step_engine #(
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned OUT_DIV     = 4,
  parameter int unsigned STEPS       = 32,
  parameter int unsigned LATENCY     = 12,
  parameter int unsigned IDLE_PERIOD = 32,
  localparam int unsigned NCH        = NUM_OUT + 1,
  localparam int unsigned MOD        = STEPS * OUT_DIV,
  localparam int unsigned PW         = $clog2(MOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps_en,
  input  logic              ps_dir,
  input  logic [NCH-1:0]    sel_mask,
  output logic              ps_done,
  output logic              busy,
  output logic              proto_err,
  output logic [NCH*PW-1:0] chan_phase
);
  // Named internal events, used by the bound checker
  logic           accept_evt;
  logic           op_done_evt;
  logic           idle_fire_evt;
  logic           dir_q;
  logic [NCH-1:0] mask_q;
  logic           done_q;

  ps_req_ctrl #(.NCH(NCH), .LATENCY(LATENCY)) req_i (
    .clk(clk), .rst(rst), .ps_en(ps_en), .ps_dir(ps_dir), .sel_in(sel_mask),
    .accept_o(accept_evt), .op_done_o(op_done_evt), .busy_o(busy),
    .dir_o(dir_q), .mask_o(mask_q), .err_o(proto_err)
  );

  ps_idle_timer #(.IDLE_PERIOD(IDLE_PERIOD)) idle_i (
    .clk(clk), .rst(rst), .busy(busy), .accept(accept_evt),
    .op_done(op_done_evt), .idle_fire_o(idle_fire_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    ps_phase_lane #(.MOD(MOD), .PW(PW)) lane_i (
      .clk(clk), .rst(rst),
      .step_en(op_done_evt && mask_q[i]),
      .up(dir_q),
      .phase_o(chan_phase[i*PW +: PW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= op_done_evt || idle_fire_evt;
  end
  assign ps_done = done_q;
endmodule

// File: rtl/ps_step_checker.sv
module ps_step_checker #(
  parameter int unsigned NCH = 5,
  parameter int unsigned PW  = 7,
  parameter int unsigned MOD = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              ps_en,
  input logic              ps_done,
  input logic              busy,
  input logic              proto_err,
  input logic [NCH*PW-1:0] chan_phase,
  input logic              accept_evt,
  input logic              op_done_evt
);
  // R3
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    op_done_evt |=> ps_done);
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    ps_done |=> !ps_done);
  // R4
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> busy);
  // R2
  lanes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_done_evt |=> $stable(chan_phase));
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ps_en && busy) |=> proto_err);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  // R10
  no_idle_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done_evt) |=> !ps_done);

  for (genvar i = 0; i < NCH; i++) begin : g_rng
    // R5
    lane_range_chk: assert property (@(posedge clk) disable iff (rst)
      32'(chan_phase[i*PW +: PW]) < MOD);
  end
endmodule

bind phase_step_engine ps_step_checker #(.NCH(NCH), .PW(PW), .MOD(MOD)) chk_i (
  .clk(clk), .rst(rst), .ps_en(ps_en), .ps_done(ps_done), .busy(busy),
  .proto_err(proto_err), .chan_phase(chan_phase),
  .accept_evt(accept_evt), .op_done_evt(op_done_evt)
);

// File: tb/phase_step_engine_tb_top.sv
module phase_step_engine_tb_top;
  localparam int NUM_OUT = 4;
  localparam int NCH = NUM_OUT + 1;
  localparam int MOD = 128;
  localparam int PW  = 7;
  localparam int LAT = 12;
  localparam int IDLE = 32;

  logic clk = 0, rst = 1, ps_en = 0, ps_dir = 0;
  logic [NCH-1:0] sel_mask = '0;
  logic ps_done, busy, proto_err;
  logic [NCH*PW-1:0] chan_phase;

  phase_step_engine dut_i (
    .clk(clk), .rst(rst), .ps_en(ps_en), .ps_dir(ps_dir), .sel_mask(sel_mask),
    .ps_done(ps_done), .busy(busy), .proto_err(proto_err), .chan_phase(chan_phase)
  );

  always #5 clk = ~clk;

  typedef struct {
    int acc;
    int due;
    int ph[NCH];
  } exp_t;
  exp_t q[$];

  int cyc = 0, checks = 0, errors = 0, last_done = 0;
  int model[NCH];      // phases after all queued requests
  int committed[NCH];  // phases visible now
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  function automatic int lane(int i);
    return int'(chan_phase[i*PW +: PW]);
  endfunction

  // Scoreboard monitor: compares every edge's results at the falling edge
  always @(negedge clk) if (mon_on) begin
    bit in_flight, op_due, idle_due;
    in_flight = (q.size() > 0) && (q[0].acc <= cyc) && (cyc < q[0].due);
    op_due    = (q.size() > 0) && (q[0].due == cyc);
    idle_due  = !((q.size() > 0) && (q[0].acc <= cyc)) && (cyc == last_done + IDLE);
    if (op_due) begin
      committed = q[0].ph;
      void'(q.pop_front());
    end
    check("R3/R7/R8/R10 ps_done", int'(ps_done), int'(op_due || idle_due));
    check("R4 busy", int'(busy), int'(in_flight));
    for (int i = 0; i < NCH; i++) check("R2/R6 lane phase", lane(i), committed[i]);
    if (op_due || idle_due) last_done = cyc;
  end

  // Driver: issue one request and push its expected outcome
  task automatic issue(logic up, logic [NCH-1:0] m);
    exp_t e;
    @(negedge clk); #1;
    ps_en = 1; ps_dir = up; sel_mask = m;
    for (int i = 0; i < NCH; i++)
      if (m[i]) model[i] = (model[i] + MOD + (up ? 1 : -1)) % MOD;
    e.acc = cyc + 1; e.due = cyc + 1 + LAT; e.ph = model;
    q.push_back(e);
    @(negedge clk); #1;
    ps_en = 0;
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin model[i] = 0; committed[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst = 0;
    last_done = cyc;
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ps_done", int'(ps_done), 0);
    check("R1 proto_err", int'(proto_err), 0);
    for (int i = 0; i < NCH; i++) check("R1 lane", lane(i), 0);
    mon_on = 1;

    // R7: idle pulses only
    repeat (70) @(negedge clk);

    // R2: step up on all lanes
    issue(1'b1, 5'b11111);
    wait_drain();
    // R6: step down on lanes 0 and 2 only
    issue(1'b0, 5'b00101);
    wait_drain();
    // R5: wrap down on lane 0 (at 0) then back up
    issue(1'b0, 5'b00001);
    wait_drain();
    check("R5 wrap below zero", lane(0), MOD - 1);
    issue(1'b1, 5'b00001);
    wait_drain();
    check("R5 wrap past top", lane(0), 0);
    // R6: feedback lane alone
    issue(1'b1, 5'b10000);
    wait_drain();

    // R9 + R6: strobe while busy, mask changed mid-flight
    issue(1'b1, 5'b00010);
    sel_mask = 5'b11111;
    repeat (2) @(negedge clk);
    #1 ps_en = 1; ps_dir = 0;
    @(negedge clk);
    check("R9 proto_err set", int'(proto_err), 1);
    #1 ps_en = 0;
    wait_drain();
    repeat (40) @(negedge clk);
    check("R9 proto_err sticky", int'(proto_err), 1);

    // R8: idle spacing after a completion, then back-to-back requests
    repeat (45) @(negedge clk);
    issue(1'b0, 5'b01000);
    while (q.size() != 0) @(negedge clk);
    issue(1'b0, 5'b01000);
    wait_drain();
    repeat (80) @(negedge clk);

    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule